// File: doc/BRIEF.md
# Flash Write Status Bit Generator

This block produces the status byte and the ready/busy line that a host polls while a flash array carries out an embedded program or erase. The host reads status by pulsing a read strobe. Each rising edge of that strobe can flip one or two toggle bits, depending on the operation in progress and on the sector being read. By watching which bits flip, software can tell a running program from a running erase or from a suspended erase. It can also spot a timed-out operation.

The block also decodes the erase suspend and erase resume commands. It tracks five operating modes: idle, program, erase, erase-suspended and program-during-suspend. The array timing sequencer drives the start pulses, the completion pulse and the timeout flag. This block turns those pulses and flags into the bus-visible status. When a read targets ordinary array data, the array byte passes through unchanged.

Top module: `flash_write_status`

## Requirements
- R1: After reset the block is idle. `readyBusy` is 1, `statusOut` equals `arrayData`, and both toggle bits hold 0.
- R2: In program mode, `readyBusy` is 0. Status bit 7 is the inverse of `progData7`, and bit 6 flips on each read strobe rising edge. Bit 5 is the timeout flag, bit 3 is 0, and bit 2 holds its last value without flipping.
- R3: In erase mode, `readyBusy` is 0. Bit 7 is 0, bit 6 flips on each read, bit 3 is 1, and bit 2 flips on each read.
- R4: In erase-suspended mode, a read with `inSuspSector`=1 gives `readyBusy`=1. The status shows bit 7 = 1, bit 6 held without flipping, bit 5 = 0, bit 3 = 0, and bit 2 flipping on each read.
- R5: In erase-suspended mode, a read with `inSuspSector`=0 returns `arrayData` unchanged with `readyBusy`=1, and neither toggle bit flips.
- R6: Program-during-suspend is entered by `progStart` while erase is suspended. In this mode `readyBusy` is 0, bit 7 is the inverse of `progData7`, bit 6 flips on each read, and bits 3 and 2 are 0. `opDone` returns the block to erase-suspended.
- R7: While `timeoutFlag` is 1 in any busy mode, status bit 5 is 1. All other bits keep their in-progress behaviour, so a timed-out erase still shows bit 3 = 1 and bit 2 flipping. Bit 5 is 0 in every non-busy status view.
- R8: A command write with data B0h suspends an erase only in erase mode. Data 30h resumes only in erase-suspended mode. The command address is not decoded, any other data is ignored, a repeated resume during erase has no effect, and a new suspend is accepted after resume.
- R9: A toggle bit flips at most once per rising edge of `rdStrobe`. Holding the strobe high flips nothing further.
- R10: `opDone` ends a program or an erase and returns the block to idle. When `opDone` and a suspend command arrive in the same cycle during erase, `opDone` wins.
- R11: In every status view (not array pass-through), bits 4, 1 and 0 are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| progStart | input | 1 | Start pulse for an embedded program |
| eraseStart | input | 1 | Start pulse for an embedded erase |
| opDone | input | 1 | Embedded algorithm finished |
| timeoutFlag | input | 1 | Embedded algorithm exceeded its time limit |
| cmdWe | input | 1 | Command write strobe |
| cmdData | input | 8 | Command write data |
| inSuspSector | input | 1 | Read address lies in the erase-suspended sector |
| progData7 | input | 1 | True bit 7 of the byte being programmed |
| rdStrobe | input | 1 | Host status read strobe |
| arrayData | input | 8 | Array read data for pass-through |
| statusOut | output | 8 | Status byte or array data |
| readyBusy | output | 1 | 1 = ready, 0 = busy |

## Verification
A wrong mode register shows up in the first comparison after the faulty edge. It changes `readyBusy`, bit 3, or the choice between array data and status. A toggle flop that flips on the wrong edge, or under the wrong mode or sector, only shows on bit 6 or bit 2 one clock after the read strobe rises. The reference model therefore tracks both toggle bits through every read, including strobes held high. A mistake in command decoding stays hidden until the next status read after the command write.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;

  typedef enum logic [2:0] {
    MODE_IDLE   = 3'd0,
    MODE_PROG   = 3'd1,
    MODE_ERASE  = 3'd2,
    MODE_ESUSP  = 3'd3,
    MODE_ESPROG = 3'd4
  } opMode_e;

  typedef enum logic [1:0] {
    D7_ZERO = 2'd0,
    D7_ONE  = 2'd1,
    D7_INV  = 2'd2
  } dq7Sel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    showArray;
    logic    busy;
    logic    dq6En;
    logic    dq2En;
    dq7Sel_e dq7Sel;
    logic    dq6Show;
    logic    dq2Show;
    logic    dq3Val;
    logic    dq5Val;
  } ctrlStrb_t;

endpackage

// File: rtl/flash_stat_ctrl.sv
module flash_stat_ctrl
  import flash_stat_pkg::*;
#(
  parameter int          CMD_W        = 8,
  parameter logic [7:0]  SUSPEND_CODE = 8'hB0,
  parameter logic [7:0]  RESUME_CODE  = 8'h30
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             progStart,
  input  logic             eraseStart,
  input  logic             opDone,
  input  logic             timeoutFlag,
  input  logic             cmdWe,
  input  logic [CMD_W-1:0] cmdData,
  input  logic             inSuspSector,
  output ctrlStrb_t        strb
);

  localparam logic [CMD_W-1:0] SUSP_W = CMD_W'(SUSPEND_CODE);
  localparam logic [CMD_W-1:0] RES_W  = CMD_W'(RESUME_CODE);

  opMode_e stateQ, stateD;
  logic    suspCmd, resCmd;

  assign suspCmd = cmdWe && (cmdData == SUSP_W);
  assign resCmd  = cmdWe && (cmdData == RES_W);

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      MODE_IDLE: begin
        if (progStart)       stateD = MODE_PROG;
        else if (eraseStart) stateD = MODE_ERASE;
      end
      MODE_PROG: begin
        if (opDone) stateD = MODE_IDLE;
      end
      MODE_ERASE: begin
        if (opDone)       stateD = MODE_IDLE;
        else if (suspCmd) stateD = MODE_ESUSP;
      end
      MODE_ESUSP: begin
        if (resCmd)         stateD = MODE_ERASE;
        else if (progStart) stateD = MODE_ESPROG;
      end
      MODE_ESPROG: begin
        if (opDone) stateD = MODE_ESUSP;
      end
      default: stateD = MODE_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= MODE_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    strb = '0;
    strb.dq7Sel = D7_ZERO;
    unique case (stateQ)
      MODE_IDLE: begin
        strb.showArray = 1'b1;
      end
      MODE_PROG: begin
        strb.busy    = 1'b1;
        strb.dq6En   = 1'b1;
        strb.dq6Show = 1'b1;
        strb.dq2Show = 1'b1;
        strb.dq7Sel  = D7_INV;
        strb.dq5Val  = timeoutFlag;
      end
      MODE_ERASE: begin
        strb.busy    = 1'b1;
        strb.dq6En   = 1'b1;
        strb.dq2En   = 1'b1;
        strb.dq6Show = 1'b1;
        strb.dq2Show = 1'b1;
        strb.dq3Val  = 1'b1;
        strb.dq5Val  = timeoutFlag;
      end
      MODE_ESUSP: begin
        if (inSuspSector) begin
          strb.dq2En   = 1'b1;
          strb.dq6Show = 1'b1;
          strb.dq2Show = 1'b1;
          strb.dq7Sel  = D7_ONE;
        end else begin
          strb.showArray = 1'b1;
        end
      end
      MODE_ESPROG: begin
        strb.busy    = 1'b1;
        strb.dq6En   = 1'b1;
        strb.dq6Show = 1'b1;
        strb.dq7Sel  = D7_INV;
        strb.dq5Val  = timeoutFlag;
      end
      default: strb.showArray = 1'b1;
    endcase
  end

  // R8
  suspend_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == MODE_ERASE && suspCmd && !opDone) |=> stateQ == MODE_ESUSP);

  // R8
  resume_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == MODE_ESUSP && resCmd) |=> stateQ == MODE_ERASE);

  // R8
  erase_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == MODE_ERASE && !opDone && !suspCmd) |=> stateQ == MODE_ERASE);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((stateQ == MODE_PROG || stateQ == MODE_ERASE) && opDone) |=> stateQ == MODE_IDLE);

  // R6
  esprog_return_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == MODE_ESPROG && opDone) |=> stateQ == MODE_ESUSP);

endmodule

// File: rtl/flash_stat_dp.sv
module flash_stat_dp
  import flash_stat_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic              rdStrobe,
  input  logic              progData7,
  input  logic [DATA_W-1:0] arrayData,
  output logic [DATA_W-1:0] statusOut,
  output logic              readyBusy
);

  localparam int POS7 = 7;
  localparam int POS6 = 6;
  localparam int POS5 = 5;
  localparam int POS3 = 3;
  localparam int POS2 = 2;

  logic rdPrevQ, rdRise;
  logic dq6Q, dq2Q;
  logic dq7Bit;
  logic [DATA_W-1:0] statusVec;

  assign rdRise = rdStrobe & ~rdPrevQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPrevQ <= 1'b0;
      dq6Q    <= 1'b0;
      dq2Q    <= 1'b0;
    end else begin
      rdPrevQ <= rdStrobe;
      if (rdRise && strb.dq6En) dq6Q <= ~dq6Q;
      if (rdRise && strb.dq2En) dq2Q <= ~dq2Q;
    end
  end

  always_comb begin
    unique case (strb.dq7Sel)
      D7_ONE:  dq7Bit = 1'b1;
      D7_INV:  dq7Bit = ~progData7;
      default: dq7Bit = 1'b0;
    endcase
  end

  always_comb begin
    statusVec       = '0;
    statusVec[POS7] = dq7Bit;
    statusVec[POS6] = strb.dq6Show & dq6Q;
    statusVec[POS5] = strb.dq5Val;
    statusVec[POS3] = strb.dq3Val;
    statusVec[POS2] = strb.dq2Show & dq2Q;
  end

  assign statusOut = strb.showArray ? arrayData : statusVec;
  assign readyBusy = ~strb.busy;

  // R9
  held_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && rdPrevQ) |=> ($stable(dq6Q) && $stable(dq2Q)));

  // R4
  dq6_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.dq6En) |=> $stable(dq6Q));

  // R5
  dq2_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.dq2En) |=> $stable(dq2Q));

  // R11
  spare_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.showArray) |-> (statusOut[4] == 1'b0 && statusOut[1:0] == 2'b00));

endmodule

// File: rtl/flash_write_status.sv
module flash_write_status
  import flash_stat_pkg::*;
#(
  parameter int         DATA_W       = 8,
  parameter int         CMD_W        = 8,
  parameter logic [7:0] SUSPEND_CODE = 8'hB0,
  parameter logic [7:0] RESUME_CODE  = 8'h30
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              progStart,
  input  logic              eraseStart,
  input  logic              opDone,
  input  logic              timeoutFlag,
  input  logic              cmdWe,
  input  logic [CMD_W-1:0]  cmdData,
  input  logic              inSuspSector,
  input  logic              progData7,
  input  logic              rdStrobe,
  input  logic [DATA_W-1:0] arrayData,
  output logic [DATA_W-1:0] statusOut,
  output logic              readyBusy
);

  ctrlStrb_t strb;

  flash_stat_ctrl #(
    .CMD_W       (CMD_W),
    .SUSPEND_CODE(SUSPEND_CODE),
    .RESUME_CODE (RESUME_CODE)
  ) i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .progStart   (progStart),
    .eraseStart  (eraseStart),
    .opDone      (opDone),
    .timeoutFlag (timeoutFlag),
    .cmdWe       (cmdWe),
    .cmdData     (cmdData),
    .inSuspSector(inSuspSector),
    .strb        (strb)
  );

  flash_stat_dp #(
    .DATA_W(DATA_W)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .rdStrobe  (rdStrobe),
    .progData7 (progData7),
    .arrayData (arrayData),
    .statusOut (statusOut),
    .readyBusy (readyBusy)
  );

  // R7
  timeout_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (timeoutFlag && !readyBusy) |-> statusOut[5]);

  // R3
  erase_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!readyBusy && statusOut[3]) |-> (statusOut[7] == 1'b0));

endmodule

// File: tb/test_flash_write_status.sv
module test_flash_write_status;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       progStart = 0, eraseStart = 0, opDone = 0, timeoutFlag = 0;
  logic       cmdWe = 0;
  logic [7:0] cmdData = 8'h00;
  logic       inSuspSector = 0, progData7 = 0, rdStrobe = 0;
  logic [7:0] arrayData = 8'h00;
  logic [7:0] statusOut;
  logic       readyBusy;

  always #10 clk = ~clk;

  flash_write_status i_flash_write_status (
    .clk(clk), .rstN(rstN), .progStart(progStart), .eraseStart(eraseStart),
    .opDone(opDone), .timeoutFlag(timeoutFlag), .cmdWe(cmdWe), .cmdData(cmdData),
    .inSuspSector(inSuspSector), .progData7(progData7), .rdStrobe(rdStrobe),
    .arrayData(arrayData), .statusOut(statusOut), .readyBusy(readyBusy)
  );

  int    nChecks = 0;
  int    nFails  = 0;
  int    cycles  = 0;
  string phase   = "R1";

  // behavioural reference: 0 idle,1 prog,2 erase,3 suspended,4 prog-in-suspend
  int mMode = 0;
  bit mT6 = 0, mT2 = 0, mRp = 0;

  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      mMode = 0; mT6 = 0; mT2 = 0; mRp = 0;
    end else begin
      bit rise;
      rise = rdStrobe && !mRp;
      if (rise && (mMode == 1 || mMode == 2 || mMode == 4)) mT6 = !mT6;
      if (rise && (mMode == 2 || (mMode == 3 && inSuspSector))) mT2 = !mT2;
      mRp = rdStrobe;
      case (mMode)
        0: if (progStart) mMode = 1; else if (eraseStart) mMode = 2;
        1: if (opDone) mMode = 0;
        2: if (opDone) mMode = 0; else if (cmdWe && cmdData == 8'hB0) mMode = 3;
        3: if (cmdWe && cmdData == 8'h30) mMode = 2; else if (progStart) mMode = 4;
        4: if (opDone) mMode = 3;
        default: mMode = 0;
      endcase
    end
  end

  function automatic string modeTag(int m, bit sus, bit to);
    if (to && (m == 1 || m == 2 || m == 4)) return "R7";
    case (m)
      1: return "R2";
      2: return "R3";
      3: return sus ? "R4" : "R5";
      4: return "R6";
      default: return "R1";
    endcase
  endfunction

  task automatic checkVal(string tag, logic [8:0] act, logic [8:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      logic [7:0] e;
      logic       rb;
      if (mMode == 0 || (mMode == 3 && !inSuspSector)) begin
        e = arrayData; rb = 1'b1;
      end else begin
        e = 8'h00;
        e[7] = (mMode == 1 || mMode == 4) ? !progData7 : (mMode == 3);
        e[6] = mT6;
        e[5] = timeoutFlag && (mMode != 3);
        e[3] = (mMode == 2);
        e[2] = (mMode == 4) ? 1'b0 : mT2;
        rb   = (mMode == 3);
      end
      checkVal({modeTag(mMode, inSuspSector, timeoutFlag), "/", phase},
               {readyBusy, statusOut}, {rb, e});
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic pulseRead(int hold = 1);
    rdStrobe = 1; tick(hold); rdStrobe = 0; tick();
  endtask

  task automatic cmd(logic [7:0] d);
    cmdWe = 1; cmdData = d; tick(); cmdWe = 0; cmdData = 8'h00;
  endtask

  initial begin
    arrayData = 8'h5A;
    tick(3);
    rstN = 1;
    #5;
    // R1 reset state
    checkVal("R1", {readyBusy, statusOut}, {1'b1, 8'h5A});
    tick(2);

    phase = "R2";
    progData7 = 1; progStart = 1; tick(); progStart = 0;
    repeat (4) pulseRead();
    progData7 = 0; repeat (3) pulseRead();
    phase = "R10"; opDone = 1; tick(); opDone = 0; tick(2);

    phase = "R3";
    eraseStart = 1; tick(); eraseStart = 0;
    repeat (5) pulseRead();
    phase = "R9"; pulseRead(6); pulseRead(3);
    phase = "R8";
    cmd(8'h30); cmd(8'h30); pulseRead();
    cmd(8'hA5); pulseRead();
    cmd(8'hB0);
    phase = "R4"; inSuspSector = 1; repeat (3) pulseRead();
    phase = "R5"; inSuspSector = 0; arrayData = 8'hC3; repeat (3) pulseRead();
    phase = "R8"; cmd(8'hB0); pulseRead();
    phase = "R6"; progData7 = 1; progStart = 1; tick(); progStart = 0;
    repeat (3) pulseRead();
    timeoutFlag = 1; phase = "R7"; pulseRead(); timeoutFlag = 0;
    phase = "R6"; opDone = 1; tick(); opDone = 0;
    inSuspSector = 1; pulseRead();
    phase = "R8"; cmd(8'h30); pulseRead();
    cmd(8'hB0); pulseRead(); cmd(8'h30);
    phase = "R7"; timeoutFlag = 1; repeat (3) pulseRead();
    phase = "R10"; opDone = 1; cmdWe = 1; cmdData = 8'hB0; tick();
    opDone = 0; cmdWe = 0; timeoutFlag = 0; tick(2);
    phase = "R7"; progStart = 1; tick(); progStart = 0; timeoutFlag = 1;
    repeat (2) pulseRead(); timeoutFlag = 0; opDone = 1; tick(); opDone = 0;

    phase = "R11";
    for (int i = 0; i < 3000; i++) begin
      progStart    = ($urandom % 8) == 0;
      eraseStart   = ($urandom % 8) == 0;
      opDone       = ($urandom % 20) == 0;
      timeoutFlag  = ($urandom % 6) == 0;
      cmdWe        = ($urandom % 5) == 0;
      cmdData      = (($urandom % 2) == 0) ? 8'hB0 : ((($urandom % 2) == 0) ? 8'h30 : 8'($urandom));
      inSuspSector = $urandom % 2;
      progData7    = $urandom % 2;
      rdStrobe     = ($urandom % 3) == 0;
      arrayData    = 8'($urandom);
      tick();
    end
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule